// File: doc/BRIEF.md
# USB IN Endpoint Controller

This block holds the control and status logic for one USB IN endpoint. The endpoint buffer has two packet slots. A CPU-side register port reads and writes a 16-bit control/status word and pushes packet bytes into the slot being loaded. The serial-engine side raises a one-cycle pulse when an IN token arrives and then gets a registered response code. After a data response it pulls bytes, and it ends the transfer with either an acknowledge or a lost-handshake pulse.

The block keeps the DATA0/DATA1 toggle, the STALL request and the STALL-sent flag, a ready flag and a byte count for each slot, and a flush request. A flush waits until any transfer in flight has finished. It then drops only the oldest queued packet, or the partly loaded slot when no packet is queued. When the flush completes, the block clears the flush bit and pulses the interrupt output for one cycle.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the status word reads 0, `resp_vld_o` and `irq_o` are low, and a response appears only in the cycle after a `tok_in_i` pulse.
- R2: Status word layout: bit 6 (toggle clear), bit 2 and bits 15:7 always read 0. Bit 1 reads 1 while at least one packet is ready. Bit 0 reads the ready flag of the slot currently being loaded, which is 1 only when both slots hold ready packets.
- R3: Writing 1 to bit 0 marks the loaded slot ready. Packets are served oldest first. On a data response (`resp_o`=1), `tx_len_o` gives the byte count and `rd_data_o` presents the bytes in push order, advancing on each `rd_en_i`.
- R4: `hs_ack_i` at the end of a transfer frees that packet's slot and flips `data_pid_o`. With no packet left, bit 1 falls.
- R5: `hs_lost_i` ends the transfer without freeing the slot. The next token resends the same packet with the same `data_pid_o`.
- R6: Writing 1 to bit 6 forces `data_pid_o` to DATA0 (0).
- R7: While bit 4 is 1, every token is answered with STALL (`resp_o`=3), no packet is consumed, and bit 5 is set.
- R8: Bit 5 clears only when written 0. Writing 1 to it leaves it unchanged.
- R9: A token with no ready packet and bit 4 clear is answered with NAK (`resp_o`=2).
- R10: A flush requested (bit 3 written 1) while a transfer is in flight waits until the transfer ends. Until then bit 3 stays 1 and `irq_o` stays low.
- R11: An idle flush with two ready packets drops only the oldest one and keeps the second. Bit 3 clears in the same cycle that `irq_o` pulses.
- R12: Pushes beyond the slot depth are ignored, and so are pushes made while both slots are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Status word write strobe |
| csr_wdata_i | input | 16 | Status word write data |
| csr_rdata_o | output | 16 | Status word read value |
| fifo_push_i | input | 1 | Push one byte into the slot being loaded |
| fifo_data_i | input | DW | Byte to push |
| tok_in_i | input | 1 | IN token arrived (one-cycle pulse) |
| resp_vld_o | output | 1 | Response code valid (one cycle) |
| resp_o | output | 2 | 1 DATA, 2 NAK, 3 STALL |
| data_pid_o | output | 1 | Data toggle, 0 DATA0, 1 DATA1 |
| tx_len_o | output | clog2(DEPTH+1) | Byte count of the packet at the head |
| rd_en_i | input | 1 | Advance to the next byte |
| rd_data_o | output | DW | Current byte of the packet in flight |
| hs_ack_i | input | 1 | Host acknowledged the packet |
| hs_lost_i | input | 1 | Transfer ended without a handshake |
| irq_o | output | 1 | Flush-complete pulse |

## Verification
A wrong slot pointer shows up at the next data response, as a wrong `tx_len_o` or a wrong first byte. A lost ready flag turns an expected DATA into a NAK at the next token. A toggle that is out of step appears in `data_pid_o` in the same cycle as the response. A flush that runs too early or drops the wrong slot is visible one token later, as a wrong length or an unexpected NAK. The `irq_o` pulse must land exactly two cycles after the end of the transfer, or one cycle after an idle request is registered.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_DATA  = 2'd1,
    RESP_NAK   = 2'd2,
    RESP_STALL = 2'd3
  } resp_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } xfer_st_e;

  localparam int unsigned B_RDY     = 0;
  localparam int unsigned B_NE      = 1;
  localparam int unsigned B_FLUSH   = 3;
  localparam int unsigned B_STL_REQ = 4;
  localparam int unsigned B_STL_SNT = 5;
  localparam int unsigned B_CLR_TGL = 6;
endpackage

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [DW-1:0]              push_data_i,
  input  logic                       commit_i,
  input  logic                       pop_i,
  input  logic                       clr_load_i,
  input  logic                       rd_start_i,
  input  logic                       rd_i,
  output logic                       load_rdy_o,
  output logic                       any_rdy_o,
  output logic                       head_rdy_o,
  output logic [$clog2(DEPTH+1)-1:0] head_len_o,
  output logic [DW-1:0]              rd_data_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned NSLOT = 2;

  logic              wr_sel_q, rd_sel_q;
  logic [NSLOT-1:0]  rdy_w;
  logic [CW-1:0]     cnt_w [NSLOT];
  logic [CW-1:0]     rd_ptr_q;
  logic [DW-1:0]     mem_q [NSLOT][DEPTH];
  logic [CW-1:0]     load_cnt;
  logic              push_ok, commit_ok;

  assign load_rdy_o = rdy_w[wr_sel_q];
  assign load_cnt   = cnt_w[wr_sel_q];
  assign push_ok    = push_i && !load_rdy_o && (load_cnt != CW'(DEPTH));
  assign commit_ok  = commit_i && !load_rdy_o;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic          rdy_r;
    logic [CW-1:0] cnt_r;
    logic          is_wr, is_rd;
    assign is_wr = (wr_sel_q == 1'(s));
    assign is_rd = (rd_sel_q == 1'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_r <= 1'b0;
        cnt_r <= '0;
      end else if (pop_i && is_rd) begin
        rdy_r <= 1'b0;
        cnt_r <= '0;
      end else if (clr_load_i && is_wr && !rdy_r) begin
        cnt_r <= '0;
      end else if (is_wr) begin
        if (push_ok)   cnt_r <= cnt_r + 1'b1;
        if (commit_ok) rdy_r <= 1'b1;
      end
    end

    assign rdy_w[s] = rdy_r;
    assign cnt_w[s] = cnt_r;
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_sel_q][load_cnt[PW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      if (commit_ok) wr_sel_q <= ~wr_sel_q;
      if (pop_i)     rd_sel_q <= ~rd_sel_q;
      if (rd_start_i)                        rd_ptr_q <= '0;
      else if (rd_i && rd_ptr_q < head_len_o) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign head_rdy_o = rdy_w[rd_sel_q];
  assign head_len_o = cnt_w[rd_sel_q];
  assign any_rdy_o  = |rdy_w;
  assign rd_data_o  = (rd_ptr_q < head_len_o) ? mem_q[rd_sel_q][rd_ptr_q[PW-1:0]] : '0;
endmodule

// File: rtl/usb_in_ep_seq.sv
module usb_in_ep_seq
  import usb_in_ep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tok_i,
  input  logic       ack_i,
  input  logic       lost_i,
  input  logic       stall_req_i,
  input  logic       head_rdy_i,
  input  logic       flush_pend_i,
  output logic       resp_vld_o,
  output logic [1:0] resp_o,
  output logic       rd_start_o,
  output logic       pop_o,
  output logic       flush_clr_o,
  output logic       flush_go_o,
  output logic       flush_irq_o,
  output logic       stall_hit_o,
  output logic       tgl_flip_o
);
  xfer_st_e st_q, st_d;
  resp_e    resp_q, resp_d;
  logic     resp_vld_q, irq_q;
  logic     tok_acc, send, xfer_end;

  assign tok_acc     = tok_i && (st_q == ST_IDLE);
  assign send        = tok_acc && !stall_req_i && head_rdy_i;
  assign xfer_end    = (st_q == ST_XFER) && (ack_i || lost_i);
  // flush waits for idle and yields to a token in the same cycle
  assign flush_go_o  = flush_pend_i && (st_q == ST_IDLE) && !tok_i;
  assign tgl_flip_o  = (st_q == ST_XFER) && ack_i;
  assign pop_o       = tgl_flip_o || (flush_go_o && head_rdy_i);
  assign flush_clr_o = flush_go_o && !head_rdy_i;
  assign stall_hit_o = tok_acc && stall_req_i;
  assign rd_start_o  = send;

  always_comb begin
    st_d = st_q;
    if (send)          st_d = ST_XFER;
    else if (xfer_end) st_d = ST_IDLE;
  end

  always_comb begin
    if (stall_req_i)     resp_d = RESP_STALL;
    else if (head_rdy_i) resp_d = RESP_DATA;
    else                 resp_d = RESP_NAK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      resp_q     <= RESP_NONE;
      resp_vld_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      resp_vld_q <= tok_acc;
      resp_q     <= tok_acc ? resp_d : RESP_NONE;
      irq_q      <= flush_go_o;
    end
  end

  assign resp_vld_o  = resp_vld_q;
  assign resp_o      = resp_q;
  assign flush_irq_o = irq_q;
endmodule

// File: rtl/usb_in_ep_csr.sv
module usb_in_ep_csr
  import usb_in_ep_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  input  logic        stall_hit_i,
  input  logic        tgl_flip_i,
  input  logic        flush_go_i,
  input  logic        load_rdy_i,
  input  logic        any_rdy_i,
  output logic [15:0] rdata_o,
  output logic        stall_req_o,
  output logic        flush_pend_o,
  output logic        commit_o,
  output logic        tgl_o
);
  logic stall_req_q, stall_snt_q, flush_q, tgl_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[15:7], wdata_i[2:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_req_q <= 1'b0;
      stall_snt_q <= 1'b0;
      flush_q     <= 1'b0;
      tgl_q       <= 1'b0;
    end else begin
      if (we_i) stall_req_q <= wdata_i[B_STL_REQ];
      // hardware set wins over a software clear
      if (stall_hit_i)                      stall_snt_q <= 1'b1;
      else if (we_i && !wdata_i[B_STL_SNT]) stall_snt_q <= 1'b0;
      flush_q <= (flush_q && !flush_go_i) || (we_i && wdata_i[B_FLUSH]);
      if (we_i && wdata_i[B_CLR_TGL]) tgl_q <= 1'b0;
      else if (tgl_flip_i)            tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    rdata_o            = '0;
    rdata_o[B_RDY]     = load_rdy_i;
    rdata_o[B_NE]      = any_rdy_i;
    rdata_o[B_FLUSH]   = flush_q;
    rdata_o[B_STL_REQ] = stall_req_q;
    rdata_o[B_STL_SNT] = stall_snt_q;
  end

  assign stall_req_o  = stall_req_q;
  assign flush_pend_o = flush_q;
  assign commit_o     = we_i && wdata_i[B_RDY];
  assign tgl_o        = tgl_q;
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       csr_we_i,
  input  logic [15:0]                csr_wdata_i,
  output logic [15:0]                csr_rdata_o,
  input  logic                       fifo_push_i,
  input  logic [DW-1:0]              fifo_data_i,
  input  logic                       tok_in_i,
  output logic                       resp_vld_o,
  output logic [1:0]                 resp_o,
  output logic                       data_pid_o,
  output logic [$clog2(DEPTH+1)-1:0] tx_len_o,
  input  logic                       rd_en_i,
  output logic [DW-1:0]              rd_data_o,
  input  logic                       hs_ack_i,
  input  logic                       hs_lost_i,
  output logic                       irq_o
);
  logic stall_req, flush_pend, commit, load_rdy, any_rdy, head_rdy;
  logic rd_start, pop, flush_clr, flush_go, stall_hit, tgl_flip;

  usb_in_ep_csr i_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (csr_we_i),
    .wdata_i      (csr_wdata_i),
    .stall_hit_i  (stall_hit),
    .tgl_flip_i   (tgl_flip),
    .flush_go_i   (flush_go),
    .load_rdy_i   (load_rdy),
    .any_rdy_i    (any_rdy),
    .rdata_o      (csr_rdata_o),
    .stall_req_o  (stall_req),
    .flush_pend_o (flush_pend),
    .commit_o     (commit),
    .tgl_o        (data_pid_o)
  );

  usb_in_ep_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tok_i        (tok_in_i),
    .ack_i        (hs_ack_i),
    .lost_i       (hs_lost_i),
    .stall_req_i  (stall_req),
    .head_rdy_i   (head_rdy),
    .flush_pend_i (flush_pend),
    .resp_vld_o   (resp_vld_o),
    .resp_o       (resp_o),
    .rd_start_o   (rd_start),
    .pop_o        (pop),
    .flush_clr_o  (flush_clr),
    .flush_go_o   (flush_go),
    .flush_irq_o  (irq_o),
    .stall_hit_o  (stall_hit),
    .tgl_flip_o   (tgl_flip)
  );

  usb_in_ep_buf #(.DW(DW), .DEPTH(DEPTH)) i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (fifo_push_i),
    .push_data_i (fifo_data_i),
    .commit_i    (commit),
    .pop_i       (pop),
    .clr_load_i  (flush_clr),
    .rd_start_i  (rd_start),
    .rd_i        (rd_en_i),
    .load_rdy_o  (load_rdy),
    .any_rdy_o   (any_rdy),
    .head_rdy_o  (head_rdy),
    .head_len_o  (tx_len_o),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/usb_in_ep_chk.sv
module usb_in_ep_chk #(
  parameter int unsigned DEPTH = 64
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tok_in_i,
  input logic [15:0]                csr_rdata_o,
  input logic                       resp_vld_o,
  input logic [1:0]                 resp_o,
  input logic [$clog2(DEPTH+1)-1:0] tx_len_o,
  input logic                       irq_o
);
  // R1
  resp_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_vld_o |-> $past(tok_in_i));

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rdata_o[15:6] == '0) && !csr_rdata_o[2]);

  // R3
  data_needs_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_vld_o && resp_o == 2'd1) |-> $past(csr_rdata_o[1]));

  // R7
  stall_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_vld_o && $past(csr_rdata_o[4])) |-> (resp_o == 2'd3));

  // R7
  stall_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_vld_o && resp_o == 2'd3) |-> csr_rdata_o[5]);

  // R9
  nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_vld_o && !$past(csr_rdata_o[1]) && !$past(csr_rdata_o[4])) |-> (resp_o == 2'd2));

  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(csr_rdata_o[3]));

  // R12
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_len_o <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind usb_in_ep_ctrl usb_in_ep_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tok_in_i    (tok_in_i),
  .csr_rdata_o (csr_rdata_o),
  .resp_vld_o  (resp_vld_o),
  .resp_o      (resp_o),
  .tx_len_o    (tx_len_o),
  .irq_o       (irq_o)
);

// File: tb/test_usb_in_ep_ctrl.sv
`timescale 1ns/1ps
module test_usb_in_ep_ctrl;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          csr_we = 1'b0;
  logic [15:0]   csr_wd = '0;
  logic [15:0]   csr_rd;
  logic          push = 1'b0;
  logic [DW-1:0] push_d = '0;
  logic          tok = 1'b0;
  logic          resp_vld;
  logic [1:0]    resp;
  logic          pid;
  logic [CW-1:0] tx_len;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_d;
  logic          ack = 1'b0, lost = 1'b0;
  logic          irq;

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit stall_sh = 1'b0;
  bit exp_tgl = 1'b0;

  always #4 clk = ~clk;

  usb_in_ep_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_usb_in_ep_ctrl (
    .clk_i (clk), .rst_ni (rst_ni),
    .csr_we_i (csr_we), .csr_wdata_i (csr_wd), .csr_rdata_o (csr_rd),
    .fifo_push_i (push), .fifo_data_i (push_d),
    .tok_in_i (tok), .resp_vld_o (resp_vld), .resp_o (resp),
    .data_pid_o (pid), .tx_len_o (tx_len),
    .rd_en_i (rd_en), .rd_data_o (rd_d),
    .hs_ack_i (ack), .hs_lost_i (lost), .irq_o (irq)
  );

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'((base + i * 3) & 8'hff);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic csr_raw(input logic [15:0] w);
    csr_we = 1'b1; csr_wd = w;
    @(negedge clk);
    csr_we = 1'b0; csr_wd = '0;
  endtask

  // keeps bit5 and the current STALL request
  task automatic wr(input logic [15:0] w);
    csr_raw(w | 16'h0020 | (stall_sh ? 16'h0010 : 16'h0000));
  endtask

  task automatic load(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      push = 1'b1; push_d = pat(base, i);
      @(negedge clk);
    end
    push = 1'b0;
  endtask

  task automatic token(output logic [1:0] r, output logic p, input string req);
    tok = 1'b1;
    @(negedge clk);
    tok = 1'b0;
    chk(resp_vld == 1'b1, req, resp_vld, 1);
    r = resp; p = pid;
  endtask

  task automatic read_pkt(input int len, input int base, input string req);
    for (int i = 0; i < len; i++) begin
      chk(rd_d == pat(base, i), req, rd_d, pat(base, i));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
  endtask

  task automatic finish_xfer(input bit acked);
    if (acked) ack = 1'b1; else lost = 1'b1;
    @(negedge clk);
    ack = 1'b0; lost = 1'b0;
  endtask

  initial begin
    logic [1:0] r;
    logic p;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csr_rd == 16'h0, "R1", csr_rd, 0);
    chk(resp_vld == 1'b0, "R1", resp_vld, 0);
    chk(irq == 1'b0, "R1", irq, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(resp_vld == 1'b0, "R1", resp_vld, 0);

    // R9 empty endpoint
    token(r, p, "R9");
    chk(r == 2'd2, "R9", r, 2);

    // R3 R4 R5 sweep of every length
    for (int len = 0; len <= DEPTH; len++) begin
      int base = len * 32 + 1;
      load(len, base);
      wr(16'h0001);
      chk(csr_rd[1] == 1'b1, "R2", csr_rd[1], 1);
      chk(csr_rd[0] == 1'b0, "R2", csr_rd[0], 0);
      chk(csr_rd[6] == 1'b0, "R2", csr_rd[6], 0);
      token(r, p, "R3");
      chk(r == 2'd1, "R3", r, 1);
      chk(p == exp_tgl, "R4", p, exp_tgl);
      chk(tx_len == CW'(len), "R3", tx_len, len);
      read_pkt(len, base, "R3");
      if (len % 2 == 1) begin
        finish_xfer(1'b0);
        chk(csr_rd[1] == 1'b1, "R5", csr_rd[1], 1);
        token(r, p, "R5");
        chk(r == 2'd1, "R5", r, 1);
        chk(p == exp_tgl, "R5", p, exp_tgl);
        chk(tx_len == CW'(len), "R5", tx_len, len);
        read_pkt(len, base, "R5");
      end
      finish_xfer(1'b1);
      exp_tgl = ~exp_tgl;
      chk(pid == exp_tgl, "R4", pid, exp_tgl);
      chk(csr_rd[1] == 1'b0, "R4", csr_rd[1], 0);
    end

    // R6 toggle clear
    chk(pid == 1'b1, "R6", pid, 1);
    wr(16'h0040);
    chk(pid == 1'b0, "R6", pid, 0);
    chk(csr_rd[6] == 1'b0, "R2", csr_rd[6], 0);
    load(1, 7);
    wr(16'h0001);
    token(r, p, "R6");
    chk(p == 1'b0, "R6", p, 0);
    read_pkt(1, 7, "R6");
    finish_xfer(1'b1);
    exp_tgl = 1'b1;

    // R12 overflow
    load(DEPTH + 2, 9);
    wr(16'h0001);
    token(r, p, "R12");
    chk(tx_len == CW'(DEPTH), "R12", tx_len, DEPTH);
    read_pkt(DEPTH, 9, "R12");
    finish_xfer(1'b1);
    exp_tgl = ~exp_tgl;

    // R11 idle flush with two queued
    load(2, 8'h50); wr(16'h0001);
    load(3, 8'h70); wr(16'h0001);
    chk(csr_rd[1:0] == 2'b11, "R2", csr_rd[1:0], 3);
    load(1, 8'hEE);
    wr(16'h0008);
    chk(csr_rd[3] == 1'b1, "R11", csr_rd[3], 1);
    chk(irq == 1'b0, "R11", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R11", irq, 1);
    chk(csr_rd[3] == 1'b0, "R11", csr_rd[3], 0);
    chk(csr_rd[1:0] == 2'b10, "R11", csr_rd[1:0], 2);
    @(negedge clk);
    chk(irq == 1'b0, "R11", irq, 0);
    token(r, p, "R11");
    chk(r == 2'd1, "R11", r, 1);
    chk(tx_len == CW'(3), "R11", tx_len, 3);
    chk(p == exp_tgl, "R4", p, exp_tgl);
    read_pkt(3, 8'h70, "R11");
    finish_xfer(1'b1);
    exp_tgl = ~exp_tgl;
    wr(16'h0001);
    token(r, p, "R12");
    chk(tx_len == CW'(0), "R12", tx_len, 0);
    finish_xfer(1'b1);
    exp_tgl = ~exp_tgl;

    // R10 deferred flush
    load(2, 8'h90); wr(16'h0001);
    token(r, p, "R10");
    wr(16'h0008);
    chk(csr_rd[3] == 1'b1, "R10", csr_rd[3], 1);
    read_pkt(2, 8'h90, "R10");
    chk(irq == 1'b0, "R10", irq, 0);
    finish_xfer(1'b0);
    chk(irq == 1'b0, "R10", irq, 0);
    chk(csr_rd[3] == 1'b1, "R10", csr_rd[3], 1);
    @(negedge clk);
    chk(irq == 1'b1, "R10", irq, 1);
    chk(csr_rd[3] == 1'b0, "R10", csr_rd[3], 0);
    token(r, p, "R10");
    chk(r == 2'd2, "R10", r, 2);

    // R7 R8 stall
    stall_sh = 1'b1;
    wr(16'h0000);
    chk(csr_rd[4] == 1'b1, "R7", csr_rd[4], 1);
    load(1, 8'hA0); wr(16'h0001);
    token(r, p, "R7");
    chk(r == 2'd3, "R7", r, 3);
    chk(csr_rd[5] == 1'b1, "R7", csr_rd[5], 1);
    chk(csr_rd[1] == 1'b1, "R7", csr_rd[1], 1);
    wr(16'h0000);
    chk(csr_rd[5] == 1'b1, "R8", csr_rd[5], 1);
    csr_raw(16'h0010);
    chk(csr_rd[5] == 1'b0, "R8", csr_rd[5], 0);
    stall_sh = 1'b0;
    wr(16'h0000);
    chk(csr_rd[4] == 1'b0, "R7", csr_rd[4], 0);
    token(r, p, "R7");
    chk(r == 2'd1, "R7", r, 1);
    chk(p == exp_tgl, "R4", p, exp_tgl);
    read_pkt(1, 8'hA0, "R7");
    finish_xfer(1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule